// File: doc/BRIEF.md
# I2C Target Receive DMA Controller

This block is the receive side of an I2C target operating in packet mode. A bus front end hands it a decoded event stream: a start strobe, an address phase carrying the 7-bit address and the direction bit, a strobe per data byte, and a stop strobe. When the address phase names this target's own address, the direction is a write from the remote controller, and both the target function and receive DMA are enabled, the block stores every incoming byte through a single-cycle memory write port. It places the bytes in a buffer whose base address and length are supplied as configuration.

The block keeps three live counters: the current DMA address, the remaining buffer room and the received byte count. The received count restarts at every matching transfer and rises with each stored byte. At a normal stop the block raises a packet status group. A single write with the packet bit set clears that whole group and leaves the buffer-exhausted flag above it untouched.

The block also owns the interrupt line that the target shares with a co-resident controller engine. The controller engine contributes its own pending flag through set and clear strobes. The line is a level made from both pending flags, each gated by its enable. When one source's status is cleared while the other is still pending, the line stays asserted, so the other source's event is not lost.

Top module: `i2c_trx_dma_top`

## Requirements
- R1: After reset, `sts_q`, `rx_len`, `dma_remain`, `dma_addr`, `mem_we` and `irq` are all zero.
- R2: An address phase after a start that carries `cfg_own_addr` with `fe_rnw`=0, while `cfg_tgt_en` and `cfg_rxdma_en` are both 1, starts a receive. One cycle later `rx_len` is 0, `dma_addr` equals `cfg_buf_base` and `dma_remain` equals `cfg_buf_len`.
- R3: In the same cycle as a data byte of an active receive with room left, `mem_we` is 1, `mem_addr` equals the current `dma_addr` and `mem_wdata` equals `fe_byte`. In the next cycle `dma_addr` has advanced by one (modulo 2^ADDR_W) and `dma_remain` has dropped by one.
- R4: `rx_len` rises by one in the cycle after each stored byte, so it is correct while the transfer is still running.
- R5: While `dma_remain` is 0, data bytes produce no write and leave `rx_len`, `dma_addr` and `dma_remain` unchanged. Each such dropped byte sets status bit 4 (buffer exhausted).
- R6: A stop that ends an active receive sets status bits 3:0 together, one cycle later: bit 3 packet done, bit 2 address matched, bit 1 normal stop, bit 0 receive operation. A stop after a repeated start to another address sets none of them.
- R7: Transfers to another address, read transfers, and transfers while `cfg_rxdma_en` or `cfg_tgt_en` is 0 write nothing, and they change neither the counters nor the status.
- R8: A `sts_wr` cycle clears every status bit written as 1. If bit 3 is written as 1, bits 3:0 are all cleared. Bit 4 is cleared only by writing 1 to bit 4 itself. A new set in the same cycle takes priority over a clear.
- R9: With IRQ_REG=1, `irq` in a cycle equals (status bit 3 AND `cfg_tgt_ie`) OR (controller pending AND `cfg_ctl_ie`), as they were in the previous cycle.
- R10: If the target becomes pending while the controller is pending, `irq` stays 1 after the controller is cleared. The same holds with the two sources swapped.
- R11: `ctl_evt` sets the controller pending flag and `ctl_clr` clears it. When both are high in the same cycle, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_own_addr | input | 7 | Own target address |
| cfg_tgt_en | input | 1 | Target function enable |
| cfg_rxdma_en | input | 1 | Receive DMA enable |
| cfg_buf_base | input | ADDR_W | Receive buffer base address |
| cfg_buf_len | input | LEN_W | Receive buffer length in bytes |
| cfg_tgt_ie | input | 1 | Target interrupt enable |
| cfg_ctl_ie | input | 1 | Controller interrupt enable |
| fe_start | input | 1 | Start or repeated start seen |
| fe_addr_vld | input | 1 | Address phase valid |
| fe_addr | input | 7 | Address received in the address phase |
| fe_rnw | input | 1 | Direction bit, 1 = read |
| fe_byte_vld | input | 1 | Data byte valid |
| fe_byte | input | 8 | Data byte |
| fe_stop | input | 1 | Normal stop seen |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | 5 | Status write data, write 1 to clear |
| ctl_evt | input | 1 | Controller status set strobe |
| ctl_clr | input | 1 | Controller status clear strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| dma_addr | output | ADDR_W | Live DMA address counter |
| dma_remain | output | LEN_W | Live remaining buffer room |
| rx_len | output | LEN_W | Live received byte count |
| sts_q | output | 5 | Target status |
| irq | output | 1 | Shared interrupt line |

## Verification
The bench builds the block with ADDR_W=12, LEN_W=4 and IRQ_REG=1. A 4-bit length caps the buffer at 15 bytes, so both a full buffer and an overrun with dropped bytes are reached with short transfers. A 12-bit address space lets a buffer based at 0xFF8 wrap through zero. The registered interrupt gives a fixed one-cycle lag, which the shared-line sequences use to check that the line holds through a clear of the other source and falls only once both sources are clear.

// File: rtl/i2c_trx_pkg.sv
package i2c_trx_pkg;
   localparam int STS_W    = 5;
   localparam int STS_RX   = 0;
   localparam int STS_STOP = 1;
   localparam int STS_HIT  = 2;
   localparam int STS_PKT  = 3;
   localparam int STS_FULL = 4;
   localparam int TADDR_W  = 7;

   typedef enum logic [1:0] {
      FR_IDLE = 2'd0,
      FR_ADDR = 2'd1,
      FR_RECV = 2'd2,
      FR_SKIP = 2'd3
   } frame_e;
endpackage

// File: rtl/i2c_trx_frame.sv
module i2c_trx_frame
   import i2c_trx_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [TADDR_W-1:0] cfg_own_addr,
   input  logic               cfg_tgt_en,
   input  logic               cfg_rxdma_en,
   input  logic               fe_start,
   input  logic               fe_addr_vld,
   input  logic [TADDR_W-1:0] fe_addr,
   input  logic               fe_rnw,
   input  logic               fe_byte_vld,
   input  logic               fe_stop,
   output logic               xfer_begin,
   output logic               byte_take,
   output logic               stop_done
);
   frame_e state_q, state_d;
   logic   hit;

   assign hit = (fe_addr == cfg_own_addr) && !fe_rnw && cfg_tgt_en && cfg_rxdma_en;

   always_comb begin
      state_d    = state_q;
      xfer_begin = 1'b0;
      stop_done  = 1'b0;
      if (fe_start) begin
         state_d = FR_ADDR;
      end else if (fe_stop) begin
         stop_done = (state_q == FR_RECV);
         state_d   = FR_IDLE;
      end else if (state_q == FR_ADDR && fe_addr_vld) begin
         xfer_begin = hit;
         state_d    = hit ? FR_RECV : FR_SKIP;
      end
   end

   assign byte_take = (state_q == FR_RECV) && fe_byte_vld && cfg_rxdma_en
                      && !fe_start && !fe_stop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= FR_IDLE;
      else        state_q <= state_d;
   end

   AST_BEGIN_STOP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({xfer_begin, stop_done, byte_take})); // R6

   AST_STOP_AFTER_RECV: assert property (@(posedge clk) disable iff (!rst_n)
      stop_done |=> (state_q == FR_IDLE)); // R6
endmodule

// File: rtl/i2c_trx_dma_ctr.sv
module i2c_trx_dma_ctr #(
   parameter int ADDR_W = 16,
   parameter int LEN_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer_begin,
   input  logic              byte_take,
   input  logic [ADDR_W-1:0] cfg_buf_base,
   input  logic [LEN_W-1:0]  cfg_buf_len,
   input  logic [7:0]        fe_byte,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   output logic [ADDR_W-1:0] dma_addr,
   output logic [LEN_W-1:0]  dma_remain,
   output logic [LEN_W-1:0]  rx_len,
   output logic              overrun
);
   localparam int SUM_W = LEN_W + 1;

   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  remain_q;
   logic [LEN_W-1:0]  len_q;
   logic [LEN_W-1:0]  len_lat_q;
   logic              room;

   assign room      = (remain_q != '0);
   assign mem_we    = byte_take && room;
   assign overrun   = byte_take && !room;
   assign mem_addr  = addr_q;
   assign mem_wdata = fe_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q    <= '0;
         remain_q  <= '0;
         len_q     <= '0;
         len_lat_q <= '0;
      end else if (xfer_begin) begin
         addr_q    <= cfg_buf_base;
         remain_q  <= cfg_buf_len;
         len_q     <= '0;
         len_lat_q <= cfg_buf_len;
      end else if (mem_we) begin
         addr_q   <= addr_q + ADDR_W'(1);
         remain_q <= remain_q - LEN_W'(1);
         len_q    <= len_q + LEN_W'(1);
      end
   end

   assign dma_addr   = addr_q;
   assign dma_remain = remain_q;
   assign rx_len     = len_q;

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> (addr_q == $past(addr_q) + ADDR_W'(1))); // R3

   AST_REMAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> (remain_q == $past(remain_q) - LEN_W'(1))); // R3

   AST_LEN_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      (SUM_W'(len_q) + SUM_W'(remain_q)) == SUM_W'(len_lat_q)); // R5

   AST_DROP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> $stable(len_q) && $stable(addr_q)); // R5
endmodule

// File: rtl/i2c_trx_status.sv
module i2c_trx_status
   import i2c_trx_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stop_done,
   input  logic             overrun,
   input  logic             sts_wr,
   input  logic [STS_W-1:0] sts_wdata,
   output logic [STS_W-1:0] sts_q
);
   localparam logic [STS_W-1:0] PKT_GROUP = STS_W'((1 << (STS_PKT + 1)) - 1);
   localparam logic [STS_W-1:0] FULL_BIT  = STS_W'(1 << STS_FULL);

   logic [STS_W-1:0] clr_mask, set_mask, st_q;

   always_comb begin
      clr_mask = '0;
      if (sts_wr) begin
         clr_mask = sts_wdata;
         if (sts_wdata[STS_PKT]) clr_mask = clr_mask | PKT_GROUP;
      end
      set_mask = (stop_done ? PKT_GROUP : '0) | (overrun ? FULL_BIT : '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= (st_q & ~clr_mask) | set_mask;
   end

   assign sts_q = st_q;

   AST_STOP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_q[STS_PKT]) |-> (&st_q[STS_PKT:STS_RX])); // R6

   AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[STS_FULL] && !(sts_wr && sts_wdata[STS_FULL])) |=> st_q[STS_FULL]); // R8

   AST_PKT_GROUP_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_wr && sts_wdata[STS_PKT] && !stop_done) |=> (st_q[STS_PKT:STS_RX] == '0)); // R8
endmodule

// File: rtl/i2c_trx_irq_share.sv
module i2c_trx_irq_share #(
   parameter bit IRQ_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tgt_pend,
   input  logic tgt_ie,
   input  logic ctl_evt,
   input  logic ctl_clr,
   input  logic ctl_ie,
   output logic irq
);
   logic ctl_pend_q;
   logic src_any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctl_pend_q <= 1'b0;
      else if (ctl_evt) ctl_pend_q <= 1'b1;
      else if (ctl_clr) ctl_pend_q <= 1'b0;
   end

   assign src_any = (tgt_pend && tgt_ie) || (ctl_pend_q && ctl_ie);

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= src_any;
         end
         assign irq = irq_q;

         AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(src_any) |-> !irq_q); // R9

         AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            (tgt_pend && tgt_ie && ctl_clr) |=> irq_q); // R10
      end else begin : g_irq_comb
         assign irq = src_any;
      end
   endgenerate

   AST_CTL_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_evt |=> ctl_pend_q); // R11
endmodule

// File: rtl/i2c_trx_dma_top.sv
module i2c_trx_dma_top
   import i2c_trx_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int LEN_W   = 8,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [6:0]        cfg_own_addr,
   input  logic              cfg_tgt_en,
   input  logic              cfg_rxdma_en,
   input  logic [ADDR_W-1:0] cfg_buf_base,
   input  logic [LEN_W-1:0]  cfg_buf_len,
   input  logic              cfg_tgt_ie,
   input  logic              cfg_ctl_ie,
   input  logic              fe_start,
   input  logic              fe_addr_vld,
   input  logic [6:0]        fe_addr,
   input  logic              fe_rnw,
   input  logic              fe_byte_vld,
   input  logic [7:0]        fe_byte,
   input  logic              fe_stop,
   input  logic              sts_wr,
   input  logic [4:0]        sts_wdata,
   input  logic              ctl_evt,
   input  logic              ctl_clr,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   output logic [ADDR_W-1:0] dma_addr,
   output logic [LEN_W-1:0]  dma_remain,
   output logic [LEN_W-1:0]  rx_len,
   output logic [4:0]        sts_q,
   output logic              irq
);
   initial begin
      AST_PARAM_WIDTHS: assert (LEN_W >= 2 && LEN_W <= ADDR_W && ADDR_W <= 32)
         else $error("length width must lie between 2 and the address width"); // R3
      AST_PARAM_STS: assert (STS_W == 5 && TADDR_W == 7)
         else $error("status or address width does not match the port list"); // R8
   end

   logic xfer_begin, byte_take, stop_done, overrun;

   i2c_trx_frame u_frame (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_own_addr (cfg_own_addr),
      .cfg_tgt_en   (cfg_tgt_en),
      .cfg_rxdma_en (cfg_rxdma_en),
      .fe_start     (fe_start),
      .fe_addr_vld  (fe_addr_vld),
      .fe_addr      (fe_addr),
      .fe_rnw       (fe_rnw),
      .fe_byte_vld  (fe_byte_vld),
      .fe_stop      (fe_stop),
      .xfer_begin   (xfer_begin),
      .byte_take    (byte_take),
      .stop_done    (stop_done)
   );

   i2c_trx_dma_ctr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctr (
      .clk          (clk),
      .rst_n        (rst_n),
      .xfer_begin   (xfer_begin),
      .byte_take    (byte_take),
      .cfg_buf_base (cfg_buf_base),
      .cfg_buf_len  (cfg_buf_len),
      .fe_byte      (fe_byte),
      .mem_we       (mem_we),
      .mem_addr     (mem_addr),
      .mem_wdata    (mem_wdata),
      .dma_addr     (dma_addr),
      .dma_remain   (dma_remain),
      .rx_len       (rx_len),
      .overrun      (overrun)
   );

   i2c_trx_status u_sts (
      .clk       (clk),
      .rst_n     (rst_n),
      .stop_done (stop_done),
      .overrun   (overrun),
      .sts_wr    (sts_wr),
      .sts_wdata (sts_wdata),
      .sts_q     (sts_q)
   );

   i2c_trx_irq_share #(.IRQ_REG(IRQ_REG)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .tgt_pend (sts_q[STS_PKT]),
      .tgt_ie   (cfg_tgt_ie),
      .ctl_evt  (ctl_evt),
      .ctl_clr  (ctl_clr),
      .ctl_ie   (cfg_ctl_ie),
      .irq      (irq)
   );

   AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_rxdma_en || !fe_byte_vld) |-> !mem_we); // R7
endmodule

// File: tb/i2c_trx_dma_top_test.sv
`timescale 1ns/1ps
module i2c_trx_dma_top_test;
   localparam int AW = 12;
   localparam int LW = 4;
   localparam logic [6:0] OWN = 7'h2A;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [6:0] cfg_own_addr = OWN;
   logic cfg_tgt_en = 1'b1, cfg_rxdma_en = 1'b1, cfg_tgt_ie = 1'b0, cfg_ctl_ie = 1'b0;
   logic [AW-1:0] cfg_buf_base = '0;
   logic [LW-1:0] cfg_buf_len = '0;
   logic fe_start = 0, fe_addr_vld = 0, fe_rnw = 0, fe_byte_vld = 0, fe_stop = 0;
   logic [6:0] fe_addr = '0;
   logic [7:0] fe_byte = '0;
   logic sts_wr = 0, ctl_evt = 0, ctl_clr = 0;
   logic [4:0] sts_wdata = '0;
   logic mem_we, irq;
   logic [AW-1:0] mem_addr, dma_addr;
   logic [7:0] mem_wdata;
   logic [LW-1:0] dma_remain, rx_len;
   logic [4:0] sts_q;

   int checks = 0;
   int errors = 0;
   int wr_cnt = 0;

   always #2 clk = ~clk;

   i2c_trx_dma_top #(.ADDR_W(AW), .LEN_W(LW), .IRQ_REG(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_own_addr(cfg_own_addr), .cfg_tgt_en(cfg_tgt_en),
      .cfg_rxdma_en(cfg_rxdma_en), .cfg_buf_base(cfg_buf_base), .cfg_buf_len(cfg_buf_len),
      .cfg_tgt_ie(cfg_tgt_ie), .cfg_ctl_ie(cfg_ctl_ie), .fe_start(fe_start),
      .fe_addr_vld(fe_addr_vld), .fe_addr(fe_addr), .fe_rnw(fe_rnw),
      .fe_byte_vld(fe_byte_vld), .fe_byte(fe_byte), .fe_stop(fe_stop),
      .sts_wr(sts_wr), .sts_wdata(sts_wdata), .ctl_evt(ctl_evt), .ctl_clr(ctl_clr),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .dma_addr(dma_addr),
      .dma_remain(dma_remain), .rx_len(rx_len), .sts_q(sts_q), .irq(irq)
   );

   always @(posedge clk) if (rst_n && mem_we) wr_cnt = wr_cnt + 1;

   typedef struct packed {
      logic [6:0]  a;
      logic        rnw;
      logic [4:0]  nb;
      logic [3:0]  blen;
      logic [11:0] base;
      logic [4:0]  wr;
      logic [3:0]  len;
      logic [3:0]  rem;
      logic [11:0] daddr;
      logic [4:0]  sts;
   } vec_t;

   localparam vec_t VECS [7] = '{
      '{7'h2A, 1'b0, 5'd3,  4'd8,  12'h100, 5'd3,  4'd3,  4'd5, 12'h103, 5'h0F},
      '{7'h2A, 1'b0, 5'd8,  4'd8,  12'h200, 5'd8,  4'd8,  4'd0, 12'h208, 5'h0F},
      '{7'h2A, 1'b0, 5'd6,  4'd4,  12'h300, 5'd4,  4'd4,  4'd0, 12'h304, 5'h1F},
      '{7'h2B, 1'b0, 5'd5,  4'd8,  12'h400, 5'd0,  4'd4,  4'd0, 12'h304, 5'h00},
      '{7'h2A, 1'b1, 5'd2,  4'd8,  12'h500, 5'd0,  4'd4,  4'd0, 12'h304, 5'h00},
      '{7'h2A, 1'b0, 5'd0,  4'd8,  12'h600, 5'd0,  4'd0,  4'd8, 12'h600, 5'h0F},
      '{7'h2A, 1'b0, 5'd15, 4'd15, 12'hFF8, 5'd15, 4'd15, 4'd0, 12'h007, 5'h0F}
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic do_start();
      fe_start = 1; tick(); fe_start = 0;
   endtask

   task automatic do_addr(input logic [6:0] a, input logic rnw);
      fe_addr = a; fe_rnw = rnw; fe_addr_vld = 1; tick(); fe_addr_vld = 0;
   endtask

   task automatic do_stop();
      fe_stop = 1; tick(); fe_stop = 0;
   endtask

   task automatic do_byte(input logic [7:0] d);
      fe_byte = d; fe_byte_vld = 1; tick(); fe_byte_vld = 0;
   endtask

   task automatic sts_write(input logic [4:0] d);
      sts_wdata = d; sts_wr = 1; tick(); sts_wr = 0; sts_wdata = '0;
   endtask

   task automatic quick_xfer(input int n);
      do_start(); do_addr(OWN, 1'b0);
      for (int k = 0; k < n; k++) do_byte(8'(k));
      do_stop();
   endtask

   initial begin
      #(200000 * 4);
      errors = errors + 1;
      $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int w0;
      logic [7:0] d;
      logic match;
      tick(); tick();
      // R1 reset state
      chk(sts_q == 0, "R1", "sts_q", 32'(sts_q), 0);
      chk(rx_len == 0 && dma_remain == 0, "R1", "len/remain", 32'({rx_len, dma_remain}), 0);
      chk(dma_addr == 0, "R1", "dma_addr", 32'(dma_addr), 0);
      chk(!mem_we && !irq, "R1", "we/irq", 32'({mem_we, irq}), 0);
      rst_n = 1; tick();

      for (int v = 0; v < 7; v++) begin
         cfg_buf_base = VECS[v].base;
         cfg_buf_len  = VECS[v].blen;
         w0 = wr_cnt;
         match = (VECS[v].a == OWN) && !VECS[v].rnw;
         do_start();
         do_addr(VECS[v].a, VECS[v].rnw);
         if (match) begin
            chk(rx_len == 0, "R2", "rx_len at begin", 32'(rx_len), 0);
            chk(dma_addr == VECS[v].base, "R2", "dma_addr at begin", 32'(dma_addr), 32'(VECS[v].base));
            chk(dma_remain == VECS[v].blen, "R2", "remain at begin", 32'(dma_remain), 32'(VECS[v].blen));
         end
         for (int i = 0; i < int'(VECS[v].nb); i++) begin
            d = 8'(8'h5A + i * 7 + v);
            fe_byte = d; fe_byte_vld = 1; #1;
            if (match && i < int'(VECS[v].blen)) begin
               chk(mem_we == 1, "R3", "mem_we", 32'(mem_we), 1);
               chk(mem_addr == AW'(VECS[v].base + 12'(i)), "R3", "mem_addr", 32'(mem_addr),
                   32'(AW'(VECS[v].base + 12'(i))));
               chk(mem_wdata == d, "R3", "mem_wdata", 32'(mem_wdata), 32'(d));
            end else begin
               chk(mem_we == 0, match ? "R5" : "R7", "mem_we dropped", 32'(mem_we), 0);
            end
            tick(); fe_byte_vld = 0;
            if (match)
               chk(int'(rx_len) == ((i + 1 < int'(VECS[v].blen)) ? i + 1 : int'(VECS[v].blen)),
                   "R4", "live rx_len", 32'(rx_len), 32'(i + 1));
         end
         do_stop();
         chk(sts_q == VECS[v].sts, match ? "R6" : "R7", "status after stop", 32'(sts_q), 32'(VECS[v].sts));
         chk(wr_cnt - w0 == int'(VECS[v].wr), "R5", "write count", 32'(wr_cnt - w0), 32'(VECS[v].wr));
         chk(rx_len == VECS[v].len, "R4", "final rx_len", 32'(rx_len), 32'(VECS[v].len));
         chk(dma_remain == VECS[v].rem, "R3", "final remain", 32'(dma_remain), 32'(VECS[v].rem));
         chk(dma_addr == VECS[v].daddr, "R3", "final dma_addr", 32'(dma_addr), 32'(VECS[v].daddr));
         chk(irq == 0, "R9", "irq masked", 32'(irq), 0);
         sts_write(5'h08);
         chk(sts_q == (VECS[v].sts & 5'h10), "R8", "packet-bit clear", 32'(sts_q), 32'(VECS[v].sts & 5'h10));
         sts_write(5'h10);
         chk(sts_q == 0, "R8", "bit 4 clear", 32'(sts_q), 0);
      end

      // R8: single low bit clears only itself
      cfg_buf_base = 12'h0A0; cfg_buf_len = 4'd4;
      quick_xfer(1);
      sts_write(5'h01);
      chk(sts_q == 5'h0E, "R8", "single bit clear", 32'(sts_q), 32'h0E);
      sts_write(5'h08);

      // R7: receive DMA disabled, then target disabled
      w0 = wr_cnt;
      cfg_rxdma_en = 0; cfg_buf_base = 12'h700; cfg_buf_len = 4'd6;
      quick_xfer(3);
      chk(wr_cnt == w0 && sts_q == 0, "R7", "rx dma off", 32'({wr_cnt - w0, sts_q}), 0);
      chk(dma_addr == 12'h0A1 && rx_len == 1, "R7", "counters kept", 32'(dma_addr), 32'h0A1);
      cfg_rxdma_en = 1; cfg_tgt_en = 0;
      quick_xfer(2);
      chk(wr_cnt == w0 && sts_q == 0, "R7", "target off", 32'({wr_cnt - w0, sts_q}), 0);
      cfg_tgt_en = 1;

      // R6: repeated start to another address, then R2 reset of rx_len
      cfg_buf_base = 12'h800; cfg_buf_len = 4'd5;
      do_start(); do_addr(OWN, 1'b0); do_byte(8'h11); do_byte(8'h22);
      do_start(); do_addr(7'h11, 1'b0); do_stop();
      chk(sts_q == 0, "R6", "stop after repeated start", 32'(sts_q), 0);
      chk(rx_len == 2, "R6", "rx_len kept", 32'(rx_len), 2);
      cfg_buf_base = 12'h900;
      do_start(); do_addr(OWN, 1'b0);
      chk(rx_len == 0 && dma_addr == 12'h900, "R2", "restart count", 32'(rx_len), 0);
      do_stop(); sts_write(5'h08);

      // R9 R10 R11: shared interrupt
      cfg_tgt_ie = 1; cfg_ctl_ie = 1;
      ctl_evt = 1; tick(); ctl_evt = 0; tick();
      chk(irq == 1, "R11", "ctl set raises irq", 32'(irq), 1);
      quick_xfer(1);
      ctl_clr = 1; tick(); ctl_clr = 0; tick();
      chk(irq == 1, "R10", "target kept after ctl clear", 32'(irq), 1);
      sts_write(5'h08); tick();
      chk(irq == 0, "R9", "irq low after both clear", 32'(irq), 0);

      quick_xfer(1); tick();
      chk(irq == 1, "R9", "target raises irq", 32'(irq), 1);
      ctl_evt = 1; tick(); ctl_evt = 0;
      sts_write(5'h08); tick();
      chk(irq == 1, "R10", "ctl kept after target clear", 32'(irq), 1);
      ctl_clr = 1; tick(); ctl_clr = 0; tick();
      chk(irq == 0, "R10", "irq low after ctl clear", 32'(irq), 0);

      cfg_tgt_ie = 0;
      quick_xfer(1); tick();
      chk(irq == 0, "R9", "target masked", 32'(irq), 0);
      cfg_tgt_ie = 1; tick();
      chk(irq == 1, "R9", "unmask raises irq", 32'(irq), 1);
      sts_write(5'h08); tick();

      ctl_evt = 1; ctl_clr = 1; tick(); ctl_evt = 0; ctl_clr = 0; tick();
      chk(irq == 1, "R11", "set wins over clear", 32'(irq), 1);
      ctl_clr = 1; tick(); ctl_clr = 0; tick();
      chk(irq == 0, "R11", "ctl clear", 32'(irq), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule